// File: doc/BRIEF.md
# Auxiliary Packet Slot Store

This block keeps a handful of auxiliary data packets for a display transmitter, such as video-format and source-description infoframes. Each packet type owns one slot of byte storage. A simple register bus fills the slots with 32-bit word writes. A configuration register holds one enable bit per slot and a global enable for the whole store. A status register reports which slots the transmitter's scheduler has taken up.

The scheduler is modelled by a fixed lag. A change of a slot's effective enable shows up in its status bit only after `LAG` clock cycles, which stands in for the wait until the next blanking interval. Software follows a two-step handshake. To retire a slot it clears the slot's enable and polls until the status bit drops. It then rewrites the slot, sets the enable again and polls until the status bit rises. A packet serializer fetches bytes by packet type code and byte index. It gets data only from slots whose status is active.

Top module: `pkt_slot_ctrl`

## Requirements
- R1: After reset the configuration and status registers read zero, `slot_active` is zero, `slot_wr_err` is low and `rd_valid` is low.
- R2: Address 0x0A0 is the configuration register. Bit n (n < NUM_SLOTS) is the enable of slot n and bit 16 is the global enable. All other bits are not stored and read back as zero.
- R3: With the global enable set, a slot's status bit rises exactly `LAG` cycles after the write that sets its enable, and not earlier.
- R4: With the global enable set, a slot's status bit falls exactly `LAG` cycles after the write that clears its enable, and not earlier.
- R5: While the global enable is low, no slot is reported active. The status register at 0x0A4 and `slot_active` read zero from the cycle after the write that clears bit 16.
- R6: Writing zero to the configuration register turns off the global enable and every slot enable, and all status bits stay low afterwards.
- R7: Slot s occupies the byte addresses from 0x400 + 0x24·s. Its bytes are grouped by seven, and group g uses the words at offsets 8g and 8g+4. The first word carries bytes 7g..7g+2 in bits 7:0, 15:8 and 23:16, and its bits 31:24 are discarded. The second word carries bytes 7g+3..7g+6 in bits 7:0 up to 31:24. The ninth word of a slot stores nothing.
- R8: A write to the memory of a slot whose status bit is high leaves the slot unchanged and sets `slot_wr_err`. The flag stays high until reset. Writes to idle slots are accepted.
- R9: One cycle after `rd_req`, `rd_valid` is high and `rd_data` holds the requested byte if the addressed slot is active. Otherwise `rd_valid` is low and `rd_data` is zero.
- R10: The serializer selects a slot by packet type code: slot = type − 0x80. Types below 0x80, types at or above 0x80 + NUM_SLOTS, and byte indices of 28 or more never give `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register bus write strobe |
| bus_addr | input | 12 | Register bus byte address |
| bus_wdata | input | 32 | Register bus write data |
| bus_rdata | output | 32 | Read data for the configuration or status register (combinational) |
| slot_active | output | NUM_SLOTS | Per-slot status as taken up by the scheduler |
| slot_wr_err | output | 1 | Sticky flag for a write to an active slot |
| rd_req | input | 1 | Serializer byte request |
| rd_type | input | 8 | Packet type code of the request |
| rd_idx | input | 5 | Byte index within the packet |
| rd_valid | output | 1 | Requested byte is valid |
| rd_data | output | 8 | Requested byte |

## Verification
A bus write takes effect at the clock edge where it is presented. The configuration readback, the error flag and a global-off status change are therefore visible in the half cycle right after that edge. A status change for a single slot enable appears at the `LAG`th edge after the write edge. The bench samples the status one edge earlier to confirm it has not moved yet, then samples at the due edge. Serializer results are registered once, so the bench raises `rd_req` on a falling edge and samples `rd_valid` and `rd_data` on the next falling edge. All sampling happens on falling clock edges, away from the active edge.

// File: rtl/pkt_slot_pkg.sv
package pkt_slot_pkg;
  localparam logic [7:0] TYPE_BASE   = 8'h80;
  localparam int         GLB_BIT     = 16;
  localparam int         GROUP_BYTES = 7;
  localparam int         LO_LANES    = 3;
  localparam int         HI_LANES    = 4;

  typedef struct packed {
    logic       hit;
    logic [3:0] slot;
    logic [3:0] word;
  } slot_hit_t;
endpackage

// File: rtl/pkt_slot_decode.sv
module pkt_slot_decode
  import pkt_slot_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_BASE = 'h400,
  parameter int STRIDE    = 'h24
) (
  input  logic [ADDR_W-1:0] addr,
  output slot_hit_t         hit
);
  int offs;
  int rel;

  always_comb begin
    hit  = '0;
    rel  = 0;
    offs = int'(addr) - SLOT_BASE;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (offs >= s * STRIDE && offs < (s + 1) * STRIDE) begin
        rel      = offs - s * STRIDE;
        hit.hit  = 1'b1;
        hit.slot = 4'(s);
        hit.word = 4'(rel >> 2);
      end
    end
  end
endmodule

// File: rtl/pkt_slot_sched.sv
module pkt_slot_sched #(
  parameter int NUM_SLOTS = 4,
  parameter int LAG       = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] en,
  input  logic                 glb,
  output logic [NUM_SLOTS-1:0] active
);
  localparam int CW = $clog2(LAG + 1);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic          st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          tgt;

    assign tgt = en[i] & glb;

    always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      if (!glb) begin
        st_d  = 1'b0;
        cnt_d = '0;
      end else if (tgt != st_q) begin
        if (cnt_q == CW'(LAG - 1)) begin
          st_d  = tgt;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        cnt_d = '0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q  <= 1'b0;
        cnt_q <= '0;
      end else begin
        st_q  <= st_d;
        cnt_q <= cnt_d;
      end
    end

    assign active[i] = st_q & glb;
  end
endmodule

// File: rtl/pkt_slot_ram.sv
module pkt_slot_ram
  import pkt_slot_pkg::*;
#(
  parameter int NUM_SLOTS  = 4,
  parameter int SLOT_BYTES = 28,
  parameter int SLOT_W     = 2,
  parameter int IDX_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [3:0]        wr_word,
  input  logic [31:0]       wr_data,
  input  logic              rd_ok,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);
  localparam int GROUPS = SLOT_BYTES / GROUP_BYTES;

  logic [7:0] mem [NUM_SLOTS][SLOT_BYTES];
  int         grp, first, lanes;
  logic       word_ok;
  logic       vld_d;
  logic [7:0] dat_d;

  always_comb begin
    grp     = int'(wr_word) >> 1;
    first   = grp * GROUP_BYTES + (wr_word[0] ? LO_LANES : 0);
    lanes   = wr_word[0] ? HI_LANES : LO_LANES;
    word_ok = wr_en && (grp < GROUPS);
  end

  always_ff @(posedge clk) begin
    if (word_ok) begin
      for (int l = 0; l < HI_LANES; l++) begin
        if (l < lanes) mem[wr_slot][first + l] <= wr_data[8*l +: 8];
      end
    end
  end

  always_comb begin
    vld_d = rd_ok;
    dat_d = rd_ok ? mem[rd_slot][rd_idx] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      rd_valid <= vld_d;
      rd_data  <= dat_d;
    end
  end
endmodule

// File: rtl/pkt_slot_ctrl.sv
module pkt_slot_ctrl
  import pkt_slot_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int LAG       = 6,
  parameter int ADDR_W    = 12,
  parameter int CFG_ADDR  = 'h0A0,
  parameter int STAT_ADDR = 'h0A4,
  parameter int SLOT_BASE = 'h400,
  parameter int STRIDE    = 'h24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_SLOTS-1:0] slot_active,
  output logic                 slot_wr_err,
  input  logic                 rd_req,
  input  logic [7:0]           rd_type,
  input  logic [4:0]           rd_idx,
  output logic                 rd_valid,
  output logic [7:0]           rd_data
);
  localparam int SLOT_W     = $clog2(NUM_SLOTS);
  localparam int SLOT_BYTES = ((STRIDE / 4) / 2) * GROUP_BYTES;

  logic [1:0]           rst_sync;
  logic                 rst_i;
  logic [NUM_SLOTS-1:0] cfg_en_q, cfg_en_d;
  logic                 cfg_glb_q, cfg_glb_d;
  logic                 cfg_we;
  logic                 err_d;
  slot_hit_t            hit;
  logic [SLOT_W-1:0]    wslot;
  logic                 slot_busy;
  logic                 mem_we;
  logic [7:0]           tidx;
  logic                 rd_in_rng;
  logic                 rd_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  pkt_slot_decode #(
    .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .SLOT_BASE(SLOT_BASE), .STRIDE(STRIDE)
  ) u_dec (
    .addr(bus_addr),
    .hit (hit)
  );

  assign cfg_we    = bus_we && (int'(bus_addr) == CFG_ADDR);
  assign wslot     = hit.slot[SLOT_W-1:0];
  assign slot_busy = slot_active[wslot];
  assign mem_we    = bus_we && hit.hit && !slot_busy;

  always_comb begin
    cfg_en_d  = cfg_en_q;
    cfg_glb_d = cfg_glb_q;
    if (cfg_we) begin
      cfg_en_d  = bus_wdata[NUM_SLOTS-1:0];
      cfg_glb_d = bus_wdata[GLB_BIT];
    end
    err_d = slot_wr_err | (bus_we & hit.hit & slot_busy);
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      cfg_en_q    <= '0;
      cfg_glb_q   <= 1'b0;
      slot_wr_err <= 1'b0;
    end else begin
      cfg_en_q    <= cfg_en_d;
      cfg_glb_q   <= cfg_glb_d;
      slot_wr_err <= err_d;
    end
  end

  pkt_slot_sched #(.NUM_SLOTS(NUM_SLOTS), .LAG(LAG)) u_sched (
    .clk   (clk),
    .rst_n (rst_i),
    .en    (cfg_en_q),
    .glb   (cfg_glb_q),
    .active(slot_active)
  );

  assign tidx      = rd_type - TYPE_BASE;
  assign rd_in_rng = (rd_type >= TYPE_BASE) && (int'(tidx) < NUM_SLOTS) &&
                     (int'(rd_idx) < SLOT_BYTES);
  assign rd_ok     = rd_req && rd_in_rng && slot_active[tidx[SLOT_W-1:0]];

  pkt_slot_ram #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_BYTES(SLOT_BYTES), .SLOT_W(SLOT_W), .IDX_W(5)
  ) u_ram (
    .clk     (clk),
    .rst_n   (rst_i),
    .wr_en   (mem_we),
    .wr_slot (wslot),
    .wr_word (hit.word),
    .wr_data (bus_wdata),
    .rd_ok   (rd_ok),
    .rd_slot (tidx[SLOT_W-1:0]),
    .rd_idx  (rd_idx),
    .rd_valid(rd_valid),
    .rd_data (rd_data)
  );

  always_comb begin
    bus_rdata = '0;
    if (int'(bus_addr) == CFG_ADDR) begin
      bus_rdata[NUM_SLOTS-1:0] = cfg_en_q;
      bus_rdata[GLB_BIT]       = cfg_glb_q;
    end else if (int'(bus_addr) == STAT_ADDR) begin
      bus_rdata[NUM_SLOTS-1:0] = slot_active;
    end
  end
endmodule

// File: rtl/pkt_slot_ctrl_chk.sv
module pkt_slot_ctrl_chk #(
  parameter int NUM_SLOTS = 4,
  parameter int LAG       = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_SLOTS-1:0] cfg_en,
  input logic                 cfg_glb,
  input logic [NUM_SLOTS-1:0] slot_active,
  input logic                 slot_wr_err,
  input logic                 rd_req,
  input logic                 rd_valid,
  input logic [7:0]           rd_data
);
  localparam int CW = $clog2(LAG + 1);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_chk
    logic [CW-1:0] hi_cnt, lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_cnt <= '0;
        lo_cnt <= '0;
      end else begin
        if (cfg_en[i] && cfg_glb) hi_cnt <= (hi_cnt == CW'(LAG)) ? hi_cnt : hi_cnt + 1'b1;
        else                      hi_cnt <= '0;
        if (!cfg_en[i])           lo_cnt <= (lo_cnt == CW'(LAG)) ? lo_cnt : lo_cnt + 1'b1;
        else                      lo_cnt <= '0;
      end
    end

    a_r3_rise_after_lag: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(slot_active[i]) |-> hi_cnt == CW'(LAG));

    a_r4_fall_after_lag: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(slot_active[i]) && cfg_glb) |-> lo_cnt == CW'(LAG));
  end

  a_r5_global_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_glb |-> slot_active == '0);

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    slot_wr_err |=> slot_wr_err);

  a_r9_valid_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_req));

  a_r9_zero_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_data == 8'h00);
endmodule

bind pkt_slot_ctrl pkt_slot_ctrl_chk #(.NUM_SLOTS(NUM_SLOTS), .LAG(LAG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_en     (cfg_en_q),
  .cfg_glb    (cfg_glb_q),
  .slot_active(slot_active),
  .slot_wr_err(slot_wr_err),
  .rd_req     (rd_req),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data)
);

// File: tb/pkt_slot_ctrl_tb.sv
`timescale 1ns/1ps
module pkt_slot_ctrl_tb;
  localparam int NS   = 4;
  localparam int LAG  = 6;
  localparam int BASE = 'h400;
  localparam int STR  = 'h24;
  localparam int NB   = 28;
  localparam int CFG  = 'h0A0;
  localparam int STA  = 'h0A4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_we;
  logic [11:0]   bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NS-1:0] slot_active;
  logic          slot_wr_err;
  logic          rd_req;
  logic [7:0]    rd_type;
  logic [4:0]    rd_idx;
  logic          rd_valid;
  logic [7:0]    rd_data;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pkt_slot_ctrl #(.NUM_SLOTS(NS), .LAG(LAG)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .slot_active(slot_active),
    .slot_wr_err(slot_wr_err), .rd_req(rd_req), .rd_type(rd_type),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic logic [7:0] pat(int s, int k, int salt);
    return 8'((s * 37 + k * 5 + 3) ^ salt);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(int addr, logic [31:0] data);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 12'(addr); bus_wdata = data;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic read_reg(int addr, output logic [31:0] v);
    bus_addr = 12'(addr);
    #0.1;
    v = bus_rdata;
  endtask

  task automatic fetch(logic [7:0] typ, int idx, output logic v, output logic [7:0] d);
    @(negedge clk);
    rd_req = 1'b1; rd_type = typ; rd_idx = 5'(idx);
    @(negedge clk);
    rd_req = 1'b0;
    v = rd_valid; d = rd_data;
  endtask

  task automatic fill_slot(int s, int salt);
    for (int g = 0; g < NB / 7; g++) begin
      bus_write(BASE + s * STR + g * 8,
                {8'hEE, pat(s, 7*g+2, salt), pat(s, 7*g+1, salt), pat(s, 7*g, salt)});
      bus_write(BASE + s * STR + g * 8 + 4,
                {pat(s, 7*g+6, salt), pat(s, 7*g+5, salt), pat(s, 7*g+4, salt), pat(s, 7*g+3, salt)});
    end
    bus_write(BASE + s * STR + 32, 32'hDEADBEEF);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] r;
    logic        v;
    logic [7:0]  d;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    rd_req = 1'b0; rd_type = '0; rd_idx = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    read_reg(CFG, r); check("R1 cfg", r, 0);
    read_reg(STA, r); check("R1 status", r, 0);
    check("R1 active", 32'(slot_active), 0);
    check("R1 err", 32'(slot_wr_err), 0);
    check("R1 rd_valid", 32'(rd_valid), 0);

    // R7 fill all slots while idle
    for (int s = 0; s < NS; s++) fill_slot(s, 0);
    check("R8 no err on idle writes", 32'(slot_wr_err), 0);

    // R3 enable all, status lag
    bus_write(CFG, 32'hFFFF_FFFF);
    repeat (LAG - 1) @(negedge clk);
    check("R3 before lag", 32'(slot_active), 0);
    @(negedge clk);
    check("R3 at lag", 32'(slot_active), 32'hF);
    read_reg(STA, r); check("R3 status reg", r, 32'hF);
    read_reg(CFG, r); check("R2 cfg mask", r, 32'h0001_000F);

    // R7 R9 R10 all bytes of all slots
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < NB; k++) begin
        fetch(8'(8'h80 + s), k, v, d);
        check("R9 valid", 32'(v), 1);
        check("R7 R10 byte", 32'(d), 32'(pat(s, k, 0)));
      end

    // R8 write to active slot ignored
    bus_write(BASE + 1 * STR, 32'h00AA_BBCC);
    check("R8 err set", 32'(slot_wr_err), 1);
    fetch(8'h81, 0, v, d);
    check("R8 byte kept", 32'(d), 32'(pat(1, 0, 0)));

    // R10 out of range
    fetch(8'h7F, 0, v, d); check("R10 type 0x7F", {23'd0, v, d}, 0);
    fetch(8'h84, 0, v, d); check("R10 type 0x84", {23'd0, v, d}, 0);
    fetch(8'h80, 28, v, d); check("R10 idx 28", {23'd0, v, d}, 0);

    // R4 clear slot 2
    bus_write(CFG, 32'h0001_000B);
    repeat (LAG - 1) @(negedge clk);
    check("R4 before lag", 32'(slot_active), 32'hF);
    @(negedge clk);
    check("R4 at lag", 32'(slot_active), 32'hB);
    fetch(8'h82, 3, v, d); check("R9 idle slot", {23'd0, v, d}, 0);

    // R8 rewrite idle slot accepted, err sticky
    fill_slot(2, 8'h5A);
    check("R8 err sticky", 32'(slot_wr_err), 1);
    bus_write(CFG, 32'h0001_000F);
    repeat (LAG) @(negedge clk);
    check("R3 re-enable", 32'(slot_active), 32'hF);
    for (int k = 0; k < NB; k++) begin
      fetch(8'h82, k, v, d);
      check("R7 R8 rewritten byte", {23'd0, v, d}, {23'd1, pat(2, k, 8'h5A)});
    end

    // R5 global off
    bus_write(CFG, 32'h0000_000F);
    check("R5 global off", 32'(slot_active), 0);
    read_reg(STA, r); check("R5 status reg", r, 0);
    repeat (LAG + 2) @(negedge clk);
    check("R5 stays off", 32'(slot_active), 0);
    fetch(8'h80, 0, v, d); check("R5 R9 no read", {23'd0, v, d}, 0);

    // R6 write zero
    bus_write(CFG, 32'h0001_000F);
    repeat (LAG) @(negedge clk);
    check("R3 after global on", 32'(slot_active), 32'hF);
    bus_write(CFG, 32'h0);
    read_reg(CFG, r); check("R6 cfg zero", r, 0);
    check("R6 all idle", 32'(slot_active), 0);
    bus_write(CFG, 32'h0001_0000);
    repeat (LAG + 2) @(negedge clk);
    check("R6 none enabled", 32'(slot_active), 0);

    summary();
  end
endmodule